// File: doc/BRIEF.md
# Address Translation Mode Control

This block holds the translation-control state of a single-hart core. It contains the supervisor page-table pointer register, the two hypervisor pointer registers (virtual-supervisor and guest-physical stage), and the hypervisor enable bit of the ISA register. It also decides from the current privilege level and the virtualization flag which translation stages are active. Software reaches it through a plain CSR port: a 12-bit address, write data, a write strobe and combinational read data. A write lands on the clock edge where the strobe is high. The outputs feed a TLB and page-table walker, which are not part of this block. Those outputs are one enable per stage and the root page-table number of each stage.

Three parameters pick the variant:
- `XLEN` is 32 or 64.
- `MMU_EN` says whether paging hardware exists.
- `HYP_EN` says whether the hypervisor extension exists.

Mode fields are WARL and gated by these parameters. A field whose feature is configured away stays at zero, and writes to it are dropped without any signal. A write that carries an unsupported mode value is dropped as a whole, so the register keeps its previous legal mode and page-table number.

Top module: `xlat_ctl`

## Requirements
- R1: After reset, the registers at 0x180, 0x280 and 0x680 read 0, the hypervisor bit (bit 7 of 0x301) reads 0, and all three stage enables are low.
- R2: With XLEN=32 and MMU_EN=1, any write to 0x180 is stored whole. Bit 31 is the mode (1 selects Sv32), bits 21:0 are the root PPN, and bits 30:22 are kept as written.
- R3: With XLEN=64 and MMU_EN=1, a write to 0x180 whose bits 63:60 are 0 (bare) or 8 (Sv39) is stored whole. Bits 43:0 are the root PPN and bits 59:44 are kept as written.
- R4: A write to 0x180, 0x280 or 0x680 whose mode nibble (bits 63:60) is neither 0 nor 8 leaves the whole register unchanged.
- R5: With MMU_EN=0, register 0x180 always reads 0, writes to it are ignored, and the supervisor stage enable stays low.
- R6: Register 0x301 reads the base-width code in its top two bits (1 for XLEN=32, 2 for XLEN=64) and the hypervisor bit at bit 7. All other bits read 0. A write changes only bit 7.
- R7: The hypervisor option is present only when HYP_EN=1 and XLEN=64. When it is absent, bit 7 of 0x301 stays 0, registers 0x280 and 0x680 read 0, and writes to all of these are ignored. Registers 0x280 and 0x680 also need MMU_EN=1.
- R8: With the hypervisor option present, registers 0x280 (virtual-supervisor pointer) and 0x680 (guest-physical pointer) use the 64-bit layout. A mode of 8 selects Sv39 or Sv39x4 respectively.
- R9: The supervisor enable is high exactly when all of these hold: the privilege input is not machine mode (encoding 2'b11; 2'b00 is user and 2'b01 is supervisor), it is not the case that both the virtualization input and the hypervisor bit are 1, and the mode field of 0x180 is non-zero.
- R10: The virtual-supervisor and guest-stage enables are high exactly when all of these hold: the virtualization input is 1, the hypervisor bit is 1, the privilege is below machine mode, and the mode field of 0x280 or 0x680 respectively is non-zero.
- R11: Each root PPN output always equals the low bits of its register: 22 bits for XLEN=32 and 44 bits for XLEN=64.
- R12: Reads of any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for `csr_addr` |
| priv_lvl | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| virt_on | input | 1 | Hart is running a guest |
| hyp_on | output | 1 | Hypervisor bit currently set |
| s_xlat_en | output | 1 | Supervisor-stage translation active |
| s_root_ppn | output | PPN_W | Supervisor root page-table number |
| vs_xlat_en | output | 1 | Virtual-supervisor translation active |
| vs_root_ppn | output | PPN_W | Virtual-supervisor root page-table number |
| g_xlat_en | output | 1 | Guest-physical stage translation active |
| g_root_ppn | output | PPN_W | Guest-physical stage root page-table number |

## Verification
Some behaviours are checked by the assertions on every cycle:
- a stored 64-bit mode nibble is always 0 or 8;
- an illegal write never disturbs a register, and a legal write lands exactly;
- the hypervisor bit follows only its own writes;
- no stage is enabled in machine mode, and no guest stage is enabled without virtualization and the hypervisor bit;
- a root PPN output agrees with the read port.

Other behaviours need the bench's scenarios. These cover the parameter variants, where a 32-bit build, a fully configured build and a build without paging or hypervisor run side by side. They also cover the exact read values of the ISA register and the silence of unmapped addresses. Finally, they cover the combined effect of sequences of legal and illegal writes mixed with privilege and virtualization changes.

// File: rtl/xlat_pkg.sv
// Shared constants and helpers for the translation-control bank.
// Assumes CSR addresses are 12 bits and that mode nibbles follow the
// 64-bit pointer layout (bits 63:60) whenever XLEN is 64.
package xlat_pkg;

    localparam logic [11:0] ADDR_SATP  = 12'h180;
    localparam logic [11:0] ADDR_VSATP = 12'h280;
    localparam logic [11:0] ADDR_HGATP = 12'h680;
    localparam logic [11:0] ADDR_MISA  = 12'h301;

    localparam int          HBIT       = 7;

    localparam logic [3:0]  MODE_BARE  = 4'd0;
    localparam logic [3:0]  MODE_SV39  = 4'd8;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    // True when the mode carried by a write is one this bank accepts.
    function automatic logic mode_legal(input int xlen, input logic [63:0] v);
        if (xlen == 32) begin
            return 1'b1;
        end
        return (v[63:60] == MODE_BARE) || (v[63:60] == MODE_SV39);
    endfunction

endpackage

// File: rtl/xlat_atp_reg.sv
// One page-table pointer register with WARL mode filtering.
// When PRESENT is 0, the register is tied to zero and writes are dropped.
// Assumes wr_en is already qualified by the address decode.
module xlat_atp_reg #(
    parameter int XLEN    = 64,
    parameter bit PRESENT = 1'b1,
    parameter int PPN_W   = 44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] value,
    output logic            mode_on,
    output logic [PPN_W-1:0] root_ppn
);
    localparam int MODE_LSB = (XLEN == 32) ? 31 : 60;

    generate
        if (PRESENT) begin : g_store
            logic [XLEN-1:0] q;
            logic            legal;

            // Decide whether the incoming mode value is supported.
            always_comb legal = xlat_pkg::mode_legal(XLEN, 64'(wdata));

            // Capture a whole legal write; drop an illegal one entirely.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && legal) begin
                    q <= wdata;
                end
            end

            assign value = q;

            p_keep_on_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && !legal |=> $stable(q));

            p_take_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && legal |=> q == $past(wdata));

            p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(q));

            if (XLEN == 64) begin : g_mode_chk
                p_mode_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (q[63:60] == xlat_pkg::MODE_BARE) || (q[63:60] == xlat_pkg::MODE_SV39));
            end
        end else begin : g_tie
            logic unused_inputs;
            assign unused_inputs = ^{wr_en, wdata, clk, rst_n};
            assign value = '0;
        end
    endgenerate

    assign mode_on  = |value[XLEN-1:MODE_LSB];
    assign root_ppn = value[PPN_W-1:0];

endmodule

// File: rtl/xlat_hext_bit.sv
// Hypervisor-enable bit of the ISA register; the only writable bit there.
// When PRESENT is 0, the bit is tied low and writes are dropped.
module xlat_hext_bit #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wbit,
    output logic h_on
);
    generate
        if (PRESENT) begin : g_bit
            logic q;

            // Load the hypervisor bit on a write to the ISA register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (wr_en) begin
                    q <= wbit;
                end
            end

            assign h_on = q;

            p_h_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> q == $past(wbit));

            p_h_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(q));
        end else begin : g_tie
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, wr_en, wbit};
            assign h_on = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/xlat_gate.sv
// Combines the stored mode flags with privilege and virtualization
// to produce the per-stage translation enables.
// Assumes priv_lvl uses 2'b11 for machine mode.
module xlat_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_lvl,
    input  logic       virt_on,
    input  logic       hyp_on,
    input  logic       s_mode_on,
    input  logic       vs_mode_on,
    input  logic       g_mode_on,
    output logic       s_en,
    output logic       vs_en,
    output logic       g_en
);
    logic below_m;
    logic guest;

    // Qualify privilege and guest context, then each stage.
    always_comb begin
        below_m = (priv_lvl != xlat_pkg::PRIV_M);
        guest   = virt_on && hyp_on;
        s_en    = below_m && !guest && s_mode_on;
        vs_en   = below_m && guest && vs_mode_on;
        g_en    = below_m && guest && g_mode_on;
    end

    p_mach_bare_r9: assert property (@(posedge clk) disable iff (!rst_n)
        priv_lvl == xlat_pkg::PRIV_M |-> !s_en && !vs_en && !g_en);

    p_guest_needs_virt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(virt_on && hyp_on) |-> !vs_en && !g_en);

    p_one_first_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_en && vs_en));

endmodule

// File: rtl/xlat_ctl.sv
// Top of the translation-control bank: decodes the CSR port, holds the
// pointer registers and the hypervisor bit, and drives stage enables.
// Assumes a single hart and a combinational read port.
module xlat_ctl #(
    parameter int XLEN   = 64,
    parameter bit MMU_EN = 1'b1,
    parameter bit HYP_EN = 1'b1,
    localparam int PPN_W = (XLEN == 32) ? 22 : 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [11:0]      csr_addr,
    input  logic             csr_we,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    input  logic [1:0]       priv_lvl,
    input  logic             virt_on,
    output logic             hyp_on,
    output logic             s_xlat_en,
    output logic [PPN_W-1:0] s_root_ppn,
    output logic             vs_xlat_en,
    output logic [PPN_W-1:0] vs_root_ppn,
    output logic             g_xlat_en,
    output logic [PPN_W-1:0] g_root_ppn
);
    import xlat_pkg::*;

    localparam bit         HYP_OK = HYP_EN && (XLEN == 64);
    localparam bit         G_OK   = HYP_OK && MMU_EN;
    localparam logic [1:0] MXL    = (XLEN == 32) ? 2'd1 : 2'd2;

    logic            wr_satp, wr_vsatp, wr_hgatp, wr_misa;
    logic [XLEN-1:0] satp_q, vsatp_q, hgatp_q;
    logic            s_mode, vs_mode, g_mode;
    logic [XLEN-1:0] misa_rd;

    // Decode write strobes per register.
    always_comb begin
        wr_satp  = csr_we && (csr_addr == ADDR_SATP);
        wr_vsatp = csr_we && (csr_addr == ADDR_VSATP);
        wr_hgatp = csr_we && (csr_addr == ADDR_HGATP);
        wr_misa  = csr_we && (csr_addr == ADDR_MISA);
    end

    xlat_atp_reg #(.XLEN(XLEN), .PRESENT(MMU_EN), .PPN_W(PPN_W)) u_satp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_satp), .wdata(csr_wdata),
        .value(satp_q), .mode_on(s_mode), .root_ppn(s_root_ppn));

    xlat_atp_reg #(.XLEN(XLEN), .PRESENT(G_OK), .PPN_W(PPN_W)) u_vsatp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_vsatp), .wdata(csr_wdata),
        .value(vsatp_q), .mode_on(vs_mode), .root_ppn(vs_root_ppn));

    xlat_atp_reg #(.XLEN(XLEN), .PRESENT(G_OK), .PPN_W(PPN_W)) u_hgatp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_hgatp), .wdata(csr_wdata),
        .value(hgatp_q), .mode_on(g_mode), .root_ppn(g_root_ppn));

    xlat_hext_bit #(.PRESENT(HYP_OK)) u_hbit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_misa), .wbit(csr_wdata[HBIT]),
        .h_on(hyp_on));

    xlat_gate u_gate (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .virt_on(virt_on),
        .hyp_on(hyp_on), .s_mode_on(s_mode), .vs_mode_on(vs_mode),
        .g_mode_on(g_mode), .s_en(s_xlat_en), .vs_en(vs_xlat_en),
        .g_en(g_xlat_en));

    // Assemble the visible ISA register value.
    always_comb begin
        misa_rd                  = '0;
        misa_rd[XLEN-1:XLEN-2]   = MXL;
        misa_rd[HBIT]            = hyp_on;
    end

    // Select read data by address; unmapped addresses read zero.
    always_comb begin
        case (csr_addr)
            ADDR_SATP:  csr_rdata = satp_q;
            ADDR_VSATP: csr_rdata = vsatp_q;
            ADDR_HGATP: csr_rdata = hgatp_q;
            ADDR_MISA:  csr_rdata = misa_rd;
            default:    csr_rdata = '0;
        endcase
    end

    p_satp_ppn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == ADDR_SATP |-> csr_rdata[PPN_W-1:0] == s_root_ppn);

    p_hgatp_ppn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == ADDR_HGATP |-> csr_rdata[PPN_W-1:0] == g_root_ppn);

    p_hyp_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_on |-> !vs_xlat_en && !g_xlat_en);

    p_hyp_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        csr_addr == ADDR_MISA |-> csr_rdata[HBIT] == hyp_on);

endmodule

// File: tb/xlat_ctl_test.sv
`timescale 1ns/100ps
module xlat_ctl_test;

    localparam logic [11:0] A_SATP  = 12'h180;
    localparam logic [11:0] A_VSATP = 12'h280;
    localparam logic [11:0] A_HGATP = 12'h680;
    localparam logic [11:0] A_MISA  = 12'h301;
    localparam logic [11:0] A_NONE  = 12'h7C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [63:0] wdata = '0;
    logic [1:0]  priv = 2'b11;
    logic        virt = 1'b0;

    logic [63:0] rd0, rd2;
    logic [31:0] rd1;
    logic        h0, h1, h2;
    logic        se0, se1, se2, ve0, ve1, ve2, ge0, ge1, ge2;
    logic [43:0] sp0, vp0, gp0, sp2, vp2, gp2;
    logic [21:0] sp1, vp1, gp1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Models per configuration: 0 = 64/full, 1 = 32-bit, 2 = 64/no MMU, no hyp
    int          XL [3] = '{64, 32, 64};
    bit          MM [3] = '{1'b1, 1'b1, 1'b0};
    bit          HY [3] = '{1'b1, 1'b1, 1'b0};
    logic [63:0] ms [3];
    logic [63:0] mv [3];
    logic [63:0] mg [3];
    logic        mh [3];

    always #2.5 clk = ~clk;

    xlat_ctl #(.XLEN(64), .MMU_EN(1'b1), .HYP_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata),
        .csr_rdata(rd0), .priv_lvl(priv), .virt_on(virt), .hyp_on(h0),
        .s_xlat_en(se0), .s_root_ppn(sp0), .vs_xlat_en(ve0), .vs_root_ppn(vp0),
        .g_xlat_en(ge0), .g_root_ppn(gp0));

    xlat_ctl #(.XLEN(32), .MMU_EN(1'b1), .HYP_EN(1'b1)) uut32 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata[31:0]),
        .csr_rdata(rd1), .priv_lvl(priv), .virt_on(virt), .hyp_on(h1),
        .s_xlat_en(se1), .s_root_ppn(sp1), .vs_xlat_en(ve1), .vs_root_ppn(vp1),
        .g_xlat_en(ge1), .g_root_ppn(gp1));

    xlat_ctl #(.XLEN(64), .MMU_EN(1'b0), .HYP_EN(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wdata),
        .csr_rdata(rd2), .priv_lvl(priv), .virt_on(virt), .hyp_on(h2),
        .s_xlat_en(se2), .s_root_ppn(sp2), .vs_xlat_en(ve2), .vs_root_ppn(vp2),
        .g_xlat_en(ge2), .g_root_ppn(gp2));

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit legal64(logic [63:0] d);
        return (d[63:60] == 4'd0) || (d[63:60] == 4'd8);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 3; i++) begin
            ms[i] = '0; mv[i] = '0; mg[i] = '0; mh[i] = 1'b0;
        end
    endfunction

    function automatic void model_wr(logic [11:0] a, logic [63:0] d);
        for (int i = 0; i < 3; i++) begin
            bit hok = HY[i] && (XL[i] == 64);
            bit gok = hok && MM[i];
            if (a == A_SATP && MM[i]) begin
                if (XL[i] == 32) ms[i] = {32'd0, d[31:0]};
                else if (legal64(d)) ms[i] = d;
            end
            if (a == A_VSATP && gok && legal64(d)) mv[i] = d;
            if (a == A_HGATP && gok && legal64(d)) mg[i] = d;
            if (a == A_MISA && hok) mh[i] = d[7];
        end
    endfunction

    function automatic logic [63:0] exp_rd(int i, logic [11:0] a);
        logic [63:0] m;
        case (a)
            A_SATP:  return ms[i];
            A_VSATP: return mv[i];
            A_HGATP: return mg[i];
            A_MISA: begin
                m = '0;
                if (XL[i] == 32) m[31:30] = 2'd1;
                else m[63:62] = 2'd2;
                m[7] = mh[i];
                return m;
            end
            default: return '0;
        endcase
    endfunction

    function automatic logic [63:0] act_rd(int i);
        case (i)
            0: return rd0;
            1: return {32'd0, rd1};
            default: return rd2;
        endcase
    endfunction

    function automatic string rd_tag(int i, logic [11:0] a);
        if (a == A_NONE) return "R12";
        if (a == A_MISA) return (i == 0) ? "R6" : "R7";
        if (i == 1) return (a == A_SATP) ? "R2" : "R7";
        if (i == 2) return (a == A_SATP) ? "R5" : "R7";
        return (a == A_SATP) ? "R3" : "R8";
    endfunction

    function automatic bit smode(int i);
        return (XL[i] == 32) ? ms[i][31] : (ms[i][63:60] != 4'd0);
    endfunction

    function automatic logic [63:0] ppn(int i, logic [63:0] v);
        return (XL[i] == 32) ? {42'd0, v[21:0]} : {20'd0, v[43:0]};
    endfunction

    // Compare every read value, enable and PPN of all three builds.
    task automatic check_state();
        logic [11:0] al [5];
        al = '{A_SATP, A_VSATP, A_HGATP, A_MISA, A_NONE};
        for (int k = 0; k < 5; k++) begin
            addr = al[k];
            #0.2;
            for (int i = 0; i < 3; i++) begin
                chk(rd_tag(i, al[k]), $sformatf("read cfg%0d addr %h", i, al[k]),
                    act_rd(i), exp_rd(i, al[k]));
            end
        end
        for (int i = 0; i < 3; i++) begin
            bit below = (priv != 2'b11);
            bit gst = virt && mh[i];
            logic as, av, ag;
            logic [63:0] ps, pv, pg;
            case (i)
                0: begin as = se0; av = ve0; ag = ge0; ps = 64'(sp0); pv = 64'(vp0); pg = 64'(gp0); end
                1: begin as = se1; av = ve1; ag = ge1; ps = 64'(sp1); pv = 64'(vp1); pg = 64'(gp1); end
                default: begin as = se2; av = ve2; ag = ge2; ps = 64'(sp2); pv = 64'(vp2); pg = 64'(gp2); end
            endcase
            chk("R9", $sformatf("s_en cfg%0d", i), 64'(as), 64'(below && !gst && smode(i)));
            chk("R10", $sformatf("vs_en cfg%0d", i), 64'(av), 64'(below && gst && mv[i][63:60] != 0));
            chk("R10", $sformatf("g_en cfg%0d", i), 64'(ag), 64'(below && gst && mg[i][63:60] != 0));
            chk("R11", $sformatf("s_ppn cfg%0d", i), ps, ppn(i, ms[i]));
            chk("R11", $sformatf("vs_ppn cfg%0d", i), pv, ppn(i, mv[i]));
            chk("R11", $sformatf("g_ppn cfg%0d", i), pg, ppn(i, mg[i]));
        end
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic set_ctx(logic [1:0] p, logic v);
        @(negedge clk);
        priv = p; virt = v;
    endtask

    function automatic logic [63:0] rand_atp();
        logic [63:0] d;
        int sel;
        d = {$urandom, $urandom};
        sel = $urandom % 4;
        if (sel == 0) d[63:60] = 4'd0;
        else if (sel != 3) d[63:60] = 4'd8;
        return d;
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, checked in supervisor context so enables could rise
        priv = 2'b01;
        addr = A_SATP; #0.2;
        chk("R1", "satp reset", rd0, 64'd0);
        addr = A_VSATP; #0.2;
        chk("R1", "vsatp reset", rd0, 64'd0);
        addr = A_HGATP; #0.2;
        chk("R1", "hgatp reset", rd0, 64'd0);
        addr = A_MISA; #0.2;
        chk("R1", "hyp bit reset", 64'(rd0[7]), 64'd0);
        chk("R1", "enables reset", {61'd0, se0, ve0, ge0}, 64'd0);
        check_state();

        // R3: Sv39 in supervisor
        wr(A_SATP, {4'd8, 16'hABCD, 44'h123_4567_89AB});
        addr = A_SATP; #0.2;
        chk("R3", "satp Sv39", rd0, {4'd8, 16'hABCD, 44'h123_4567_89AB});
        chk("R3", "s_en on", 64'(se0), 64'd1);
        check_state();

        // R4: illegal mode leaves register unchanged
        wr(A_SATP, {4'd5, 60'h0FF_FFFF_FFFF_FFFF});
        addr = A_SATP; #0.2;
        chk("R4", "satp after illegal", rd0, {4'd8, 16'hABCD, 44'h123_4567_89AB});
        check_state();

        // R2: 32-bit build, bit 31 mode
        wr(A_SATP, 64'h0000_0000_C040_1234);
        addr = A_SATP; #0.2;
        chk("R2", "satp32 read", 64'(rd1), 64'hC040_1234);
        chk("R2", "satp32 ppn", 64'(sp1), 64'h00_1234);
        chk("R2", "satp32 s_en", 64'(se1), 64'd1);
        chk("R5", "no-MMU satp", rd2, 64'd0);
        chk("R5", "no-MMU s_en", 64'(se2), 64'd0);

        // R9: machine mode disables translation
        set_ctx(2'b11, 1'b0);
        #0.2;
        chk("R9", "machine mode s_en", 64'(se0), 64'd0);

        // R6, R7: hypervisor bit
        wr(A_MISA, 64'hFFFF_FFFF_FFFF_FFFF);
        addr = A_MISA; #0.2;
        chk("R6", "misa read", rd0, 64'h8000_0000_0000_0080);
        chk("R7", "misa32 no hyp", 64'(rd1), 64'h4000_0000);
        chk("R7", "misa no hyp", rd2, 64'h8000_0000_0000_0000);

        // R8, R10: guest stages
        wr(A_VSATP, {4'd8, 60'h0000_0AB_CDEF_0123});
        wr(A_HGATP, {4'd8, 60'h0000_0FE_DCBA_9876});
        set_ctx(2'b01, 1'b1);
        #0.2;
        chk("R10", "vs_en guest", 64'(ve0), 64'd1);
        chk("R10", "g_en guest", 64'(ge0), 64'd1);
        chk("R9", "s_en off in guest", 64'(se0), 64'd0);
        chk("R7", "vs_en no hyp", 64'(ve2), 64'd0);
        check_state();

        // R4 on hgatp, R12 unmapped write
        wr(A_HGATP, {4'd9, 60'd1});
        wr(A_NONE, 64'hFFFF_FFFF_FFFF_FFFF);
        check_state();

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom % 7;
            case (kind)
                0: wr(A_SATP, rand_atp());
                1: wr(A_VSATP, rand_atp());
                2: wr(A_HGATP, rand_atp());
                3: wr(A_MISA, {$urandom, $urandom});
                4: wr(A_NONE, {$urandom, $urandom});
                default: begin
                    logic [1:0] p;
                    p = 2'($urandom % 3);
                    if (p == 2'd2) p = 2'b11;
                    set_ctx(p, 1'($urandom));
                end
            endcase
            check_state();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule